// File: doc/BRIEF.md
# Execute Stage with Iterative Multiply/Divide

This block is the execute stage of a scalar in-order integer pipeline. Each cycle it takes one decoded operation with two register operands, an immediate and a shift amount. It computes the result in a single-cycle arithmetic/logic path and a barrel shifter. The result and its status flags are captured in the stage's output register on the next clock edge. Load/store address generation uses the same adder, adding a base register and a constant offset.

Multiply and divide run in a separate iterative unit that handles one operand bit per cycle. Once started, the unit runs alongside the single-cycle path, so later operations keep flowing through the stage while it works. A busy flag marks the iteration. A one-cycle done pulse marks the cycle in which the high and low result words become valid.

Top module: `exec_unit`

## Requirements
- R1: Operation codes on `op_i`: 0 AND, 1 OR, 2 XOR, 3 NOR, 4 NAND, 5 XNOR and 6 NOT (complement of A). Each produces the bitwise result of A and the selected second operand, which is `imm_i` when `use_imm_i`=1 and `src_b_i` otherwise.
- R2: Code 7 (signed add) and code 9 (signed subtract) produce the two's-complement sum or difference modulo 2^WIDTH and raise `ovf_o` on signed overflow. Code 8 (unsigned add) and code 10 (unsigned subtract) produce the same values with `ovf_o` always 0. No other code raises `ovf_o`.
- R3: `zero_o` is 1 exactly when the registered `res_o` is all zeros.
- R4: Codes 13 (shift left logical), 14 (shift right logical) and 15 (shift right arithmetic, sign-filling) shift A. The amount is `shamt_i` when `use_imm_i`=1, and the low log2(WIDTH) bits of `src_b_i` otherwise.
- R5: Code 11 gives 1 if A < B as signed numbers and 0 otherwise. Code 12 makes the same comparison as unsigned numbers.
- R6: Code 16 (move-if-zero) and code 17 (move-if-nonzero) output A as the result. `wen_o` is 1 only when B is zero (code 16) or non-zero (code 17). Every other listed code gives `wen_o`=1.
- R7: Code 18 (address generation) outputs A plus the selected second operand, modulo 2^WIDTH, with `ovf_o`=0.
- R8: `res_o`, `zero_o`, `ovf_o` and `wen_o` are registered and reflect the inputs of the previous clock edge. A synchronous active-low reset clears all outputs to 0.
- R9: `md_start_i` sampled while the unit is idle sets `md_busy_o` for exactly WIDTH cycles. `md_done_o` then pulses for one cycle with `md_busy_o` low. A start sampled while busy is ignored.
- R10: With `md_div_i`=0 the unit forms the unsigned 2·WIDTH-bit product of `md_a_i` and `md_b_i`: high half on `md_hi_o`, low half on `md_lo_o`.
- R11: With `md_div_i`=1 the unit performs unsigned restoring division, giving the quotient on `md_lo_o` and the remainder on `md_hi_o`. A zero divisor gives an all-ones quotient and the dividend as the remainder.
- R12: The single-cycle path keeps producing correct results on every cycle while the multiply/divide unit is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 5 | Operation code |
| src_a_i | input | WIDTH | First register operand |
| src_b_i | input | WIDTH | Second register operand |
| imm_i | input | WIDTH | Sign-extended immediate / offset |
| use_imm_i | input | 1 | Select immediate as second operand and `shamt_i` as shift amount |
| shamt_i | input | log2(WIDTH) | Fixed shift amount |
| res_o | output | WIDTH | Registered result |
| zero_o | output | 1 | Result is zero |
| ovf_o | output | 1 | Signed overflow of add/subtract |
| wen_o | output | 1 | Result should be written back |
| md_start_i | input | 1 | Start a multiply/divide |
| md_div_i | input | 1 | 1 = divide, 0 = multiply |
| md_a_i | input | WIDTH | Multiplicand / dividend |
| md_b_i | input | WIDTH | Multiplier / divisor |
| md_busy_o | output | 1 | Iteration in progress |
| md_done_o | output | 1 | One-cycle result-valid pulse |
| md_hi_o | output | WIDTH | Product high half / remainder |
| md_lo_o | output | WIDTH | Product low half / quotient |

## Verification
The bench targets signed overflow at both ends of the range. A design that reused the signed rule for the unsigned forms would flag 0x7FFFFFFF+1 under unsigned add. It also applies arithmetic right shifts of negative values by the largest amount, where a logical fill would give 1 instead of all ones. It checks signed and unsigned set-less-than on mixed-sign pairs, and conditional moves with zero and non-zero conditions, where an inverted test flips `wen_o`. On the iterative side it multiplies all-ones by all-ones and divides by zero. It starts a second operation mid-run, which a unit that accepts restarts would let corrupt the result. It counts the busy cycles exactly, so an off-by-one iteration count shows up as a late or early done.

// File: rtl/exu_pkg.sv
// Shared operation codes and shift kinds for the execute stage.
// Assumes a 5-bit operation field driven by the decode stage.
package exu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 5'd0,
        OP_OR   = 5'd1,
        OP_XOR  = 5'd2,
        OP_NOR  = 5'd3,
        OP_NAND = 5'd4,
        OP_XNOR = 5'd5,
        OP_NOT  = 5'd6,
        OP_ADD  = 5'd7,
        OP_ADDU = 5'd8,
        OP_SUB  = 5'd9,
        OP_SUBU = 5'd10,
        OP_SLT  = 5'd11,
        OP_SLTU = 5'd12,
        OP_SLL  = 5'd13,
        OP_SRL  = 5'd14,
        OP_SRA  = 5'd15,
        OP_MOVZ = 5'd16,
        OP_MOVN = 5'd17,
        OP_AGEN = 5'd18
    } exu_op_e;

    typedef enum logic [1:0] {
        SH_LL = 2'd0,
        SH_RL = 2'd1,
        SH_RA = 2'd2
    } sh_kind_e;

endpackage

// File: rtl/exu_alu.sv
// Single-cycle arithmetic/logic path: bitwise ops, add/subtract with
// signed overflow, compares, conditional-move enable and address add.
// Purely combinational; assumes the caller has already selected B.
module exu_alu
    import exu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  exu_op_e           op,
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    output logic [WIDTH-1:0]  res,
    output logic              ovf,
    output logic              wen
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] sum;
    logic [WIDTH-1:0] diff;
    logic             add_ovf;
    logic             sub_ovf;
    logic             b_zero;

    // Shared adder, subtractor and their signed overflow conditions.
    always_comb begin
        sum     = a + b;
        diff    = a - b;
        add_ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
        sub_ovf = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
        b_zero  = (b == '0);
    end

    // Operation select.
    always_comb begin
        res = '0;
        ovf = 1'b0;
        wen = 1'b1;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOR:  res = ~(a | b);
            OP_NAND: res = ~(a & b);
            OP_XNOR: res = ~(a ^ b);
            OP_NOT:  res = ~a;
            OP_ADD:  begin res = sum;  ovf = add_ovf; end
            OP_ADDU: res = sum;
            OP_SUB:  begin res = diff; ovf = sub_ovf; end
            OP_SUBU: res = diff;
            OP_SLT:  res = {{(WIDTH-1){1'b0}}, ($signed(a) < $signed(b))};
            OP_SLTU: res = {{(WIDTH-1){1'b0}}, (a < b)};
            OP_MOVZ: begin res = a; wen = b_zero;  end
            OP_MOVN: begin res = a; wen = !b_zero; end
            OP_AGEN: res = sum;
            default: begin res = '0; wen = 1'b0; end
        endcase
    end

endmodule

// File: rtl/exu_shift.sv
// Barrel shifter for logical left, logical right and arithmetic right.
// Combinational; the amount is already reduced to log2(WIDTH) bits.
module exu_shift
    import exu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  sh_kind_e          kind,
    input  logic [WIDTH-1:0]  a,
    input  logic [SHW-1:0]    amt,
    output logic [WIDTH-1:0]  res
);

    // Select the shift direction and fill.
    always_comb begin
        unique case (kind)
            SH_LL:   res = a << amt;
            SH_RL:   res = a >> amt;
            SH_RA:   res = $unsigned($signed(a) >>> amt);
            default: res = a;
        endcase
    end

endmodule

// File: rtl/exu_muldiv.sv
// Iterative unsigned multiply (shift-add) and restoring divide, one
// operand bit per cycle. A start while idle latches operands; busy holds
// for WIDTH cycles, then done pulses once. Starts while busy are dropped.
module exu_muldiv #(
    parameter int WIDTH = 32,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              div,
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    output logic              busy,
    output logic              done,
    output logic [WIDTH-1:0]  hi,
    output logic [WIDTH-1:0]  lo
);

    logic [WIDTH-1:0] hi_q, lo_q, opb_q;
    logic [WIDTH-1:0] hi_n, lo_n;
    logic [CW-1:0]    cnt_q;
    logic             div_q, busy_q, done_q;
    logic [WIDTH:0]   shifted, trial, addend;
    logic             ge;

    // One iteration step for the active operation.
    always_comb begin
        shifted = {hi_q, lo_q[WIDTH-1]};
        trial   = shifted - {1'b0, opb_q};
        ge      = (shifted >= {1'b0, opb_q});
        addend  = lo_q[0] ? ({1'b0, hi_q} + {1'b0, opb_q}) : {1'b0, hi_q};
        if (div_q) begin
            hi_n = ge ? trial[WIDTH-1:0] : shifted[WIDTH-1:0];
            lo_n = {lo_q[WIDTH-2:0], ge};
        end else begin
            {hi_n, lo_n} = {addend, lo_q[WIDTH-1:1]};
        end
    end

    // Sequencer: accept a start when idle, iterate, then pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            lo_q   <= '0;
            opb_q  <= '0;
            cnt_q  <= '0;
            div_q  <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                hi_q  <= hi_n;
                lo_q  <= lo_n;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end else if (start) begin
                hi_q   <= '0;
                lo_q   <= a;
                opb_q  <= b;
                div_q  <= div;
                cnt_q  <= CW'(WIDTH);
                busy_q <= 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign hi   = hi_q;
    assign lo   = lo_q;

endmodule

// File: rtl/exec_unit.sv
// Execute stage: selects the second operand and shift amount, routes the
// operation to the ALU or shifter, and registers result and flags. The
// iterative multiply/divide unit runs independently alongside.
module exec_unit
    import exu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [WIDTH-1:0]  src_a_i,
    input  logic [WIDTH-1:0]  src_b_i,
    input  logic [WIDTH-1:0]  imm_i,
    input  logic              use_imm_i,
    input  logic [SHW-1:0]    shamt_i,
    output logic [WIDTH-1:0]  res_o,
    output logic              zero_o,
    output logic              ovf_o,
    output logic              wen_o,
    input  logic              md_start_i,
    input  logic              md_div_i,
    input  logic [WIDTH-1:0]  md_a_i,
    input  logic [WIDTH-1:0]  md_b_i,
    output logic              md_busy_o,
    output logic              md_done_o,
    output logic [WIDTH-1:0]  md_hi_o,
    output logic [WIDTH-1:0]  md_lo_o
);

    exu_op_e          op;
    sh_kind_e         sh_kind;
    logic [WIDTH-1:0] opnd_b, alu_res, sh_res, nxt_res;
    logic [SHW-1:0]   amt;
    logic             alu_ovf, alu_wen, is_shift;

    // Operand, amount and shift-kind selection.
    always_comb begin
        op       = exu_op_e'(op_i);
        opnd_b   = use_imm_i ? imm_i : src_b_i;
        amt      = use_imm_i ? shamt_i : src_b_i[SHW-1:0];
        is_shift = (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
        unique case (op)
            OP_SRL:  sh_kind = SH_RL;
            OP_SRA:  sh_kind = SH_RA;
            default: sh_kind = SH_LL;
        endcase
    end

    exu_alu #(.WIDTH(WIDTH)) u_alu (
        .op  (op),
        .a   (src_a_i),
        .b   (opnd_b),
        .res (alu_res),
        .ovf (alu_ovf),
        .wen (alu_wen)
    );

    exu_shift #(.WIDTH(WIDTH)) u_shift (
        .kind (sh_kind),
        .a    (src_a_i),
        .amt  (amt),
        .res  (sh_res)
    );

    // Result mux between the two single-cycle paths.
    always_comb nxt_res = is_shift ? sh_res : alu_res;

    // Stage output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o  <= '0;
            zero_o <= 1'b0;
            ovf_o  <= 1'b0;
            wen_o  <= 1'b0;
        end else begin
            res_o  <= nxt_res;
            zero_o <= (nxt_res == '0);
            ovf_o  <= is_shift ? 1'b0 : alu_ovf;
            wen_o  <= is_shift ? 1'b1 : alu_wen;
        end
    end

    exu_muldiv #(.WIDTH(WIDTH)) u_md (
        .clk   (clk),
        .rst_n (rst_n),
        .start (md_start_i),
        .div   (md_div_i),
        .a     (md_a_i),
        .b     (md_b_i),
        .busy  (md_busy_o),
        .done  (md_done_o),
        .hi    (md_hi_o),
        .lo    (md_lo_o)
    );

endmodule

// File: rtl/exu_chk.sv
// Protocol checks on the execute stage ports, bound into exec_unit.
module exu_chk
    import exu_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [OP_W-1:0] op_i,
    input logic            ovf_o,
    input logic            md_start_i,
    input logic            md_busy_o,
    input logic            md_done_o
);

    // R2
    ovf_signed_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> ($past(op_i) == OP_ADD || $past(op_i) == OP_SUB));

    // R9
    md_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        md_done_o |=> !md_done_o);

    // R9
    md_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        md_done_o |-> !md_busy_o);

    // R9
    md_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(md_busy_o) |-> md_done_o);

    // R9
    md_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (md_start_i && !md_busy_o) |=> md_busy_o);

endmodule

bind exec_unit exu_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .ovf_o      (ovf_o),
    .md_start_i (md_start_i),
    .md_busy_o  (md_busy_o),
    .md_done_o  (md_done_o)
);

// File: tb/exec_unit_tb.sv
// Self-checking bench with a behavioural reference model.
module exec_unit_tb;

    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [4:0]    op_i = '0;
    logic [W-1:0]  src_a_i = '0, src_b_i = '0, imm_i = '0;
    logic          use_imm_i = 1'b0;
    logic [4:0]    shamt_i = '0;
    logic [W-1:0]  res_o;
    logic          zero_o, ovf_o, wen_o;
    logic          md_start_i = 1'b0, md_div_i = 1'b0;
    logic [W-1:0]  md_a_i = '0, md_b_i = '0;
    logic          md_busy_o, md_done_o;
    logic [W-1:0]  md_hi_o, md_lo_o;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    exec_unit #(.WIDTH(W)) u_dut (.*);

    function automatic string tag_of(input int op);
        if (op <= 6) return "R1";
        if (op <= 10) return "R2";
        if (op <= 12) return "R5";
        if (op <= 15) return "R4";
        if (op <= 17) return "R6";
        return "R7";
    endfunction

    // Reference: result, overflow and write enable from the requirements.
    task automatic model(input int op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input int sh, output logic [W-1:0] r, output logic v,
                         output logic w);
        longint s;
        v = 1'b0; w = 1'b1; r = '0;
        case (op)
            0: r = a & b;
            1: r = a | b;
            2: r = a ^ b;
            3: r = ~(a | b);
            4: r = ~(a & b);
            5: r = ~(a ^ b);
            6: r = ~a;
            7, 8: begin
                r = a + b;
                s = longint'($signed(a)) + longint'($signed(b));
                v = (op == 7) && ((s > 64'sd2147483647) || (s < -64'sd2147483648));
            end
            9, 10: begin
                r = a - b;
                s = longint'($signed(a)) - longint'($signed(b));
                v = (op == 9) && ((s > 64'sd2147483647) || (s < -64'sd2147483648));
            end
            11: r = ($signed(a) < $signed(b)) ? 1 : 0;
            12: r = (a < b) ? 1 : 0;
            13: r = a << sh;
            14: r = a >> sh;
            15: r = $signed(a) >>> sh;
            16: begin r = a; w = (b == 0); end
            17: begin r = a; w = (b != 0); end
            default: r = a + b;
        endcase
    endtask

    // Drive one vector at a negedge, compare at the following negedge.
    task automatic apply(input int op, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] imm, input logic ui, input int sh);
        logic [W-1:0] er;
        logic ev, ew;
        int amt;
        op_i = 5'(op); src_a_i = a; src_b_i = b; imm_i = imm;
        use_imm_i = ui; shamt_i = 5'(sh);
        amt = ui ? sh : int'(b[4:0]);
        model(op, a, ui ? imm : b, amt, er, ev, ew);
        @(negedge clk);
        n_vec++;
        if (res_o !== er || zero_o !== (er == 0) || ovf_o !== ev || wen_o !== ew) begin
            n_bad++;
            $display("FAIL %s/R3/R8 op=%0d res=%h z=%b v=%b w=%b exp res=%h z=%b v=%b w=%b",
                     tag_of(op), op, res_o, zero_o, ovf_o, wen_o, er, (er == 0), ev, ew);
        end
    endtask

    task automatic check_md(input string req, input logic ok, input logic [W-1:0] got,
                            input logic [W-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s md got=%h exp=%h busy=%b done=%b", req, got, exp,
                     md_busy_o, md_done_o);
        end
    endtask

    // Run one multiply/divide while random ALU vectors flow (R12).
    task automatic md_run(input logic dv, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] eh, el;
        logic [2*W-1:0] p;
        if (dv) begin
            if (b == 0) begin el = '1; eh = a; end
            else begin el = a / b; eh = a % b; end
        end else begin
            p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
            {eh, el} = p;
        end
        md_start_i = 1'b1; md_div_i = dv; md_a_i = a; md_b_i = b;
        apply(7, $urandom, $urandom, 0, 0, 0);
        md_start_i = 1'b0;
        check_md("R9", md_busy_o === 1'b1 && md_done_o === 1'b0, {31'd0, md_busy_o}, 1);
        for (int i = 2; i <= W + 1; i++) begin
            if (i == 3) begin
                // R9: start while busy must be ignored
                md_start_i = 1'b1; md_div_i = !dv; md_a_i = ~a; md_b_i = 3;
            end
            apply(int'($urandom % 19), $urandom, $urandom, $urandom, 1'($urandom),
                  int'($urandom % 32));
            md_start_i = 1'b0;
            if (i <= W)
                check_md("R9", md_busy_o === 1'b1 && md_done_o === 1'b0,
                         {31'd0, md_done_o}, 0);
        end
        check_md("R9", md_busy_o === 1'b0 && md_done_o === 1'b1, {31'd0, md_done_o}, 1);
        check_md(dv ? "R11" : "R10", md_lo_o === el, md_lo_o, el);
        check_md(dv ? "R11" : "R10", md_hi_o === eh, md_hi_o, eh);
        apply(0, 0, 0, 0, 0, 0);
        check_md("R9", md_done_o === 1'b0, {31'd0, md_done_o}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        n_vec++;
        if (res_o !== 0 || zero_o !== 0 || ovf_o !== 0 || wen_o !== 0 ||
            md_busy_o !== 0 || md_done_o !== 0 || md_hi_o !== 0 || md_lo_o !== 0) begin
            n_bad++;
            $display("FAIL R8 reset res=%h exp=0", res_o);
        end
        rst_n = 1'b1;
        // R1
        apply(0, 32'hF0F0_1234, 32'h0FF0_FFFF, 0, 0, 0);
        apply(3, 32'h0, 32'h0, 0, 0, 0);
        apply(5, 32'hAAAA_5555, 0, 32'hAAAA_5555, 1, 0);
        apply(6, 32'h0000_FFFF, 0, 0, 0, 0);
        apply(4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0);
        // R2
        apply(7, 32'h7FFF_FFFF, 32'h1, 0, 0, 0);
        apply(8, 32'h7FFF_FFFF, 32'h1, 0, 0, 0);
        apply(9, 32'h8000_0000, 32'h1, 0, 0, 0);
        apply(10, 32'h8000_0000, 32'h1, 0, 0, 0);
        apply(7, 32'h8000_0000, 32'h8000_0000, 0, 0, 0);
        // R3: equal operands give zero
        apply(9, 32'h1234_5678, 32'h1234_5678, 0, 0, 0);
        // R4
        apply(15, 32'h8000_0000, 0, 0, 1, 31);
        apply(14, 32'h8000_0000, 32'hFFFF_FFFF, 0, 0, 0);
        apply(13, 32'h0000_0003, 32'h0000_0021, 0, 0, 0);
        apply(15, 32'h7000_0000, 32'h4, 0, 0, 0);
        // R5
        apply(11, 32'hFFFF_FFFF, 32'h1, 0, 0, 0);
        apply(12, 32'hFFFF_FFFF, 32'h1, 0, 0, 0);
        // R6
        apply(16, 32'hCAFE_0001, 32'h0, 0, 0, 0);
        apply(16, 32'hCAFE_0002, 32'h5, 0, 0, 0);
        apply(17, 32'hCAFE_0003, 32'h0, 0, 0, 0);
        apply(17, 32'hCAFE_0004, 32'h8000_0000, 0, 0, 0);
        // R7
        apply(18, 32'h7FFF_FFF0, 0, 32'h0000_0020, 1, 0);
        apply(18, 32'h0000_1000, 0, 32'hFFFF_FFFC, 1, 0);
        // R10 / R11 / R12
        md_run(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        md_run(1'b0, 32'd12345, 32'd6789);
        md_run(1'b1, 32'd100, 32'd7);
        md_run(1'b1, 32'hDEAD_BEEF, 32'd0);
        md_run(1'b1, 32'd5, 32'd9);
        for (int k = 0; k < 4; k++) md_run(1'($urandom), $urandom, $urandom);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule